// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address with a small, fully associative translation buffer. On each request the page number part of the address is compared against the tag of every stored entry at the same time. The entry that matches, if any, has its permission bits checked against the kind of access asked for: read, write or instruction fetch. Its physical frame number is then joined with the page offset, which passes through untranslated. The result is registered, so the answer arrives one cycle after the request.

Entries are loaded through a fill port. The block picks the slot itself, using a round-robin pointer that moves on by one slot on every fill. A global flush input drops every entry in a single cycle. Pages are 4 KiB, and addresses are 32 bits on both sides. The buffer holds 16 entries by default. Walking page tables, mixed page sizes and address-space tags are left to other logic.

Top module: `tlb_lookup`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_valid, rsp_hit and rsp_fault are low and no entry is valid, so every lookup misses.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and low otherwise.
- R3: When a request matches a valid entry whose permission allows the access, the next cycle shows rsp_hit=1, rsp_fault=0 and rsp_paddr = {entry frame number, req_vaddr[11:0]}.
- R4: When a request matches no valid entry, the next cycle shows rsp_hit=0 and rsp_fault=0.
- R5: fill_perm and req_kind are encoded as follows. fill_perm bit 0 allows read, bit 1 allows write and bit 2 allows fetch. req_kind 0 is a read, 1 a write, 2 a fetch, and 3 is reserved and never permitted. If a request matches an entry that lacks the required bit, the next cycle shows rsp_fault=1 and rsp_hit=0.
- R6: Fills go to slots 0, 1, 2 and so on in order, wrapping after the last slot. After ENTRIES+1 fills of distinct pages the first page has been overwritten and misses, while the second page still hits.
- R7: Filling a page number that is already present invalidates the older copy. Lookups then return the newest frame, and at most one entry ever matches.
- R8: A flush makes every entry invalid from the next cycle on. A fill presented in the same cycle as a flush is dropped.
- R9: A lookup presented in the same cycle as a fill sees the contents from before that fill.
- R10: A cycle with no request produces rsp_hit=0 and rsp_fault=0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| fill_en | input | 1 | Write one entry at the round-robin slot |
| fill_vpn | input | VA_W-OFF_W | Page number tag of the new entry |
| fill_pfn | input | PA_W-OFF_W | Frame number of the new entry |
| fill_perm | input | 3 | Permissions of the new entry: bit 0 read, bit 1 write, bit 2 fetch |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | PA_W | Translated address, meaningful only when rsp_hit is high |
| rsp_hit | output | 1 | Entry matched and the access is allowed |
| rsp_fault | output | 1 | Entry matched but the access is not allowed |

## Verification
Assertions run on every cycle. They check that the match vector is never more than one-hot, that hit and fault are never high together, that the result strobe trails the request by exactly one cycle, that the page offset passes through unchanged, that idle cycles produce no hit, and that a flush empties the valid bits. Other behaviour depends on which entry holds which page, and only the bench's scenarios can show it. This covers the round-robin victim order, the dropping of a stale duplicate, the permission decode for each access kind, the loss of a fill that coincides with a flush, and the old-contents view of a lookup made during a fill.

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [1:0]             req_kind,
  input  logic                   fill_en,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PA_W-OFF_W-1:0]  fill_pfn,
  input  logic [2:0]             fill_perm,
  input  logic                   flush,
  output logic                   rsp_valid,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic                   rsp_hit,
  output logic                   rsp_fault
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] match, dup;
  logic [PFN_W-1:0]   pfn_sel;
  logic [2:0]         perm_sel;
  logic               any_match, allowed;
  wire  [VPN_W-1:0]   req_vpn = req_vaddr[VA_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid_q[i] && (tag_q[i] == req_vpn);
    assign dup[i]   = valid_q[i] && (tag_q[i] == fill_vpn);
  end

  always_comb begin
    pfn_sel  = '0;
    perm_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        pfn_sel  = pfn_sel  | pfn_q[i];
        perm_sel = perm_sel | perm_q[i];
      end
    end
  end

  assign any_match = |match;

  always_comb begin
    case (req_kind)
      2'd0:    allowed = perm_sel[0];
      2'd1:    allowed = perm_sel[1];
      2'd2:    allowed = perm_sel[2];
      default: allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q <= (valid_q & ~dup) | (ENTRIES'(1) << ptr_q);
      ptr_q   <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fill_en && !flush) begin
      tag_q[ptr_q]  <= fill_vpn;
      pfn_q[ptr_q]  <= fill_pfn;
      perm_q[ptr_q] <= fill_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_match && allowed;
      rsp_fault <= req_valid && any_match && !allowed;
      rsp_paddr <= {pfn_sel, req_vaddr[OFF_W-1:0]};
    end
  end

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R5
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: tb/tlb_lookup_test.sv
`timescale 1ns/1ps
module tlb_lookup_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tlb_lookup uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault)
  );

  localparam int NV = 10;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h40007ABC, 32'h40005456, 32'h40005123, 32'h40001FFF, 32'h40002000,
    32'h40002777, 32'h40000010, 32'h40008010, 32'h40007020, 32'h40004800};
  localparam logic [1:0] V_KIND [NV] = '{
    2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2};
  localparam logic V_HIT [NV] = '{1,0,1,1,1,0,0,0,0,1};
  localparam logic V_FLT [NV] = '{0,1,0,0,0,1,1,0,1,0};
  localparam logic [31:0] V_PA [NV] = '{
    32'hA0707ABC, 32'h0, 32'hA0505123, 32'hA0101FFF, 32'hA0202000,
    32'h0, 32'h0, 32'h0, 32'h0, 32'hA0404800};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kind);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic hit, input logic flt,
                            input logic [31:0] pa);
    check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({req, " hit"}, {31'd0, rsp_hit}, {31'd0, hit});
    check({req, " fault"}, {31'd0, rsp_fault}, {31'd0, flt});
    if (hit) check({req, " paddr"}, rsp_paddr, pa);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check("R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 hit in reset", {31'd0, rsp_hit | rsp_fault}, 32'd0);
    rst_n = 1'b1;
    lookup(32'h00000000, 2'd0);
    expect_rsp("R1 empty after reset", 1'b0, 1'b0, 32'h0);

    // R10: idle cycle after a request
    @(negedge clk);
    check("R10 idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R10 idle hit/fault", {31'd0, rsp_hit | rsp_fault}, 32'd0);

    // load entries: page 0x40000+i -> frame 0xA0000+i*0x101, perm = i
    for (int i = 0; i < 8; i++)
      fill(20'h40000 + 20'(i), 20'hA0000 + 20'(i * 32'h101), 3'(i));

    // R3 R4 R5: vector walk
    for (int v = 0; v < NV; v++) begin
      lookup(V_ADDR[v], V_KIND[v]);
      expect_rsp($sformatf("R3/R4/R5 vec%0d", v), V_HIT[v], V_FLT[v], V_PA[v]);
    end

    // R2: back-to-back requests give back-to-back results
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h40007001; req_kind = 2'd0;
    @(negedge clk);
    check("R2 first result", {31'd0, rsp_valid & rsp_hit}, 32'd1);
    req_vaddr = 32'h40001002;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 second result", rsp_paddr, 32'hA0101002);
    @(negedge clk);
    check("R2 strobe drops", {31'd0, rsp_valid}, 32'd0);

    // R8: flush empties; a fill during flush is dropped
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h55555; fill_pfn = 20'h12345; fill_perm = 3'b111;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    lookup(32'h40007000, 2'd0);
    expect_rsp("R8 flushed entry", 1'b0, 1'b0, 32'h0);
    lookup(32'h55555000, 2'd0);
    expect_rsp("R8 fill during flush", 1'b0, 1'b0, 32'h0);

    // R6: ENTRIES+1 fills overwrite the first
    for (int i = 0; i < 17; i++)
      fill(20'h20000 + 20'(i), 20'hB0000 + 20'(i), 3'b001);
    lookup(32'h20000000, 2'd0);
    expect_rsp("R6 oldest evicted", 1'b0, 1'b0, 32'h0);
    lookup(32'h20001abc, 2'd0);
    expect_rsp("R6 second kept", 1'b1, 1'b0, 32'hB0001abc);
    lookup(32'h20010def, 2'd0);
    expect_rsp("R6 newest present", 1'b1, 1'b0, 32'hB0010def);

    // R7: refill of a present page replaces the old copy
    fill(20'h20005, 20'h0F0F0, 3'b011);
    lookup(32'h20005111, 2'd1);
    expect_rsp("R7 newest frame", 1'b1, 1'b0, 32'h0F0F0111);

    // R9: lookup during fill sees old contents
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h33333; fill_pfn = 20'hC3333; fill_perm = 3'b001;
    req_valid = 1'b1; req_vaddr = 32'h33333044; req_kind = 2'd0;
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R9 same-cycle fill", 1'b0, 1'b0, 32'h0);
    lookup(32'h33333044, 2'd0);
    expect_rsp("R9 after fill", 1'b1, 1'b0, 32'hC3333044);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule